// File: doc/BRIEF.md
# Colour-Key Match Generator

This block produces an internal key flag for each pixel by comparing the three colour components of the incoming pixel with three programmable key values. The components first pass through a lane mapper. Depending on the selected input format, the mapper decides which component each comparator sees. The formats are green-blue-red, red-green-blue, luma/chroma and colour-index. In colour-index mode the single index value is copied to all three comparators.

Each comparator has its own enable, and there is one master enable. The block combines the results of the enabled comparators with a logical AND. The result is registered once, so that it lines up with a sampled external key flag. The combined key output is the OR of the registered external key and the registered data key.

A small write port loads the control register and the three key value registers. The lanes are called D, E and F in this project.

Top module: `ckey_match_top`

## Requirements
- R1: After reset, `data_key` and `key_out` are 0, all key values are 0, and all enables are off.
- R2: In green-blue-red format (`mode` = 0), lanes D, E and F compare `pix_g`, `pix_b` and `pix_r` against key values D, E and F.
- R3: In red-green-blue format (`mode` = 1), lanes D, E and F compare `pix_r`, `pix_g` and `pix_b`.
- R4: In luma/chroma format (`mode` = 2), luma arrives on `pix_g`, Cb on `pix_b` and Cr on `pix_r`, and lanes D, E and F compare luma, Cb and Cr.
- R5: In colour-index format (`mode` = 3), the index arrives on `pix_g` and all three lanes compare that same value. `pix_r` and `pix_b` are ignored.
- R6: Control register (`wr_addr` = 0) bits 3, 2 and 1 enable lanes D, E and F. A disabled lane does not affect the result.
- R7: The data key is 1 only when every enabled lane holds an exact 8-bit match.
- R8: Control bit 4 is the master enable. While it is 0, `data_key` stays 0 even on a full match.
- R9: With the master enable set but no lane enabled, `data_key` is 0.
- R10: In colour-index format, two enabled lanes that hold different key values never produce a key. One enabled lane alone is enough to produce a key.
- R11: `data_key` and the registered external key appear one clock after their pixel is sampled, and `key_out` is their OR.
- R12: A key value write (`wr_addr` 1, 2 or 3 for lanes D, E or F) acts on the pixel sampled on the clock edge after the write edge. A pixel sampled on the write edge itself still uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = control, 1..3 = key value D..F |
| wr_data | input | CW | Write data |
| mode | input | 2 | Input format select |
| pix_r | input | CW | Red component or Cr |
| pix_g | input | CW | Green component, luma or index |
| pix_b | input | CW | Blue component or Cb |
| ext_key | input | 1 | External key flag for this pixel |
| data_key | output | 1 | Registered data key |
| key_out | output | 1 | Registered external key OR data key |

## Verification
The bench builds the block with its default component width CW = 8. At that width the full 8-bit equality can be tested directly. The control word's enable bits 1 to 4 also fit inside a single write. With 8-bit values, key values that differ in one bit can be placed in different lanes, so any mix-up in the lane mapping or in the enable bits shows up at the outputs.

// File: rtl/ckey_pkg.sv
// Package: shared types and constants for the colour-key match generator.
// Assumes three lanes (D, E, F) and a control word of at least five bits.
package ckey_pkg;
    typedef enum logic [1:0] {
        MODE_GBR = 2'd0,
        MODE_RGB = 2'd1,
        MODE_YC  = 2'd2,
        MODE_CI  = 2'd3
    } ckey_mode_e;

    localparam int NUM_LANES       = 3;
    localparam int CTRL_MASTER_BIT = 4;
    // Lane i enable sits at control bit (3 - i): D=3, E=2, F=1.
    localparam int CTRL_LANE_TOP   = 3;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
endpackage

// File: rtl/ckey_regs.sv
// Module: control and key value registers behind a simple write port.
// Assumes CW >= 5 so the control bits fit in one write word.
module ckey_regs
    import ckey_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_addr,
    input  logic [CW-1:0]                 wr_data,
    output logic                          master_en,
    output logic [NUM_LANES-1:0]          lane_en,
    output logic [NUM_LANES-1:0][CW-1:0]  key_val
);
    logic                 master_q;
    logic [NUM_LANES-1:0] lane_en_q;

    // Control register: master enable and per-lane enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q  <= 1'b0;
            lane_en_q <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            master_q <= wr_data[CTRL_MASTER_BIT];
            for (int i = 0; i < NUM_LANES; i++) begin
                lane_en_q[i] <= wr_data[CTRL_LANE_TOP - i];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_key
            logic [CW-1:0] val_q;
            // Key value register for lane g, at address g+1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_en && wr_addr == 2'(g + 1)) begin
                    val_q <= wr_data;
                end
            end
            assign key_val[g] = val_q;
        end
    endgenerate

    assign master_en = master_q;
    assign lane_en   = lane_en_q;
endmodule

// File: rtl/ckey_lane_map.sv
// Module: routes pixel components onto the three compare lanes by input format.
// Assumes luma on the green input, Cb on blue, Cr on red, and the index on green.
module ckey_lane_map
    import ckey_pkg::*;
#(
    parameter int CW = 8
) (
    input  ckey_mode_e                    mode,
    input  logic [CW-1:0]                 pix_r,
    input  logic [CW-1:0]                 pix_g,
    input  logic [CW-1:0]                 pix_b,
    output logic [NUM_LANES-1:0][CW-1:0]  lane_val
);
    // Format-dependent lane selection.
    always_comb begin
        unique case (mode)
            MODE_RGB: begin
                lane_val[0] = pix_r;
                lane_val[1] = pix_g;
                lane_val[2] = pix_b;
            end
            MODE_CI: begin
                lane_val[0] = pix_g;
                lane_val[1] = pix_g;
                lane_val[2] = pix_g;
            end
            default: begin // MODE_GBR and MODE_YC share the lane order
                lane_val[0] = pix_g;
                lane_val[1] = pix_b;
                lane_val[2] = pix_r;
            end
        endcase
    end
endmodule

// File: rtl/ckey_compare.sv
// Module: per-lane equality compare and AND combine over the enabled lanes.
// Purely combinational; the caller registers the result.
module ckey_compare
    import ckey_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                          master_en,
    input  logic [NUM_LANES-1:0]          lane_en,
    input  logic [NUM_LANES-1:0][CW-1:0]  key_val,
    input  logic [NUM_LANES-1:0][CW-1:0]  lane_val,
    output logic                          match
);
    logic [NUM_LANES-1:0] lane_ok;

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_cmp
            // A lane passes when it is disabled or its value matches exactly.
            assign lane_ok[g] = !lane_en[g] || (lane_val[g] == key_val[g]);
        end
    endgenerate

    // A key needs the master enable, at least one enabled lane, and all lanes passing.
    always_comb begin
        match = master_en && (|lane_en) && (&lane_ok);
    end
endmodule

// File: rtl/ckey_match_top.sv
// Module: colour-key match generator top level.
// Registers the data key and the external key once, so both have one
// clock of latency, and ORs them onto key_out.
module ckey_match_top
    import ckey_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] pix_r,
    input  logic [CW-1:0] pix_g,
    input  logic [CW-1:0] pix_b,
    input  logic          ext_key,
    output logic          data_key,
    output logic          key_out
);
    logic                          master_en;
    logic [NUM_LANES-1:0]          lane_en;
    logic [NUM_LANES-1:0][CW-1:0]  key_val;
    logic [NUM_LANES-1:0][CW-1:0]  lane_val;
    logic                          match_raw;
    logic                          data_key_q;
    logic                          ext_key_q;
    ckey_mode_e                    mode_e;

    assign mode_e = ckey_mode_e'(mode);

    ckey_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .master_en (master_en),
        .lane_en   (lane_en),
        .key_val   (key_val)
    );

    ckey_lane_map #(.CW(CW)) u_map (
        .mode     (mode_e),
        .pix_r    (pix_r),
        .pix_g    (pix_g),
        .pix_b    (pix_b),
        .lane_val (lane_val)
    );

    ckey_compare #(.CW(CW)) u_cmp (
        .master_en (master_en),
        .lane_en   (lane_en),
        .key_val   (key_val),
        .lane_val  (lane_val),
        .match     (match_raw)
    );

    // Output stage: align the data key with the sampled external key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_key_q <= 1'b0;
            ext_key_q  <= 1'b0;
        end else begin
            data_key_q <= match_raw;
            ext_key_q  <= ext_key;
        end
    end

    assign data_key = data_key_q;
    assign key_out  = data_key_q | ext_key_q;
endmodule

// File: rtl/ckey_match_chk.sv
// Checker: temporal properties of the colour-key match generator, bound to the top.
module ckey_match_chk
    import ckey_pkg::*;
#(
    parameter int CW = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [1:0]                    wr_addr,
    input logic [CW-1:0]                 wr_data,
    input logic [1:0]                    mode,
    input logic                          ext_key,
    input logic                          data_key,
    input logic                          key_out,
    input logic                          master_en,
    input logic [NUM_LANES-1:0]          lane_en,
    input logic [NUM_LANES-1:0][CW-1:0]  key_val,
    input logic [NUM_LANES-1:0][CW-1:0]  lane_val
);
    // R8: master enable off blocks the next data key
    p_master_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !data_key);

    // R9: no lane enabled gives no key
    p_no_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_en == '0) |=> !data_key);

    // R10: conflicting enabled D/E values in index mode never key
    p_ci_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CI && lane_en[0] && lane_en[1] && key_val[0] != key_val[1])
        |=> !data_key);

    // R5: index mode feeds one value to all lanes
    p_ci_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CI) |-> (lane_val[0] == lane_val[1] && lane_val[1] == lane_val[2]));

    // R11: external key reaches key_out one clock later
    p_ext_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_key |=> key_out);

    // R11: key_out has no source other than the two keys
    p_out_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        key_out |-> (data_key || $past(ext_key)));

    // R12: a key D write is visible on the next edge
    p_write_d_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (key_val[0] == $past(wr_data)));
endmodule

bind ckey_match_top ckey_match_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode      (mode),
    .ext_key   (ext_key),
    .data_key  (data_key),
    .key_out   (key_out),
    .master_en (master_en),
    .lane_en   (lane_en),
    .key_val   (key_val),
    .lane_val  (lane_val)
);

// File: tb/tb_ckey_match_top.sv
// Directed bench for the colour-key match generator.
module tb_ckey_match_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [1:0]    mode = '0;
    logic [CW-1:0] pix_r = '0;
    logic [CW-1:0] pix_g = '0;
    logic [CW-1:0] pix_b = '0;
    logic          ext_key = 1'b0;
    logic          data_key;
    logic          key_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    ckey_match_top #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .pix_r(pix_r), .pix_g(pix_g),
        .pix_b(pix_b), .ext_key(ext_key), .data_key(data_key), .key_out(key_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Write one register; inputs change on the falling edge.
    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Present one pixel and sample the registered result after the next edge.
    task automatic pix(input logic [1:0] m, input logic [7:0] r, input logic [7:0] g,
                       input logic [7:0] b, input logic ek, input logic exp_dk,
                       input logic exp_ko, input string req);
        @(negedge clk);
        mode = m; pix_r = r; pix_g = g; pix_b = b; ext_key = ek;
        @(posedge clk); #1;
        check({req, " data_key"}, data_key, exp_dk);
        check({req, " key_out"}, key_out, exp_ko);
    endtask

    task automatic load_keys(input logic [7:0] d, input logic [7:0] e, input logic [7:0] f);
        wr(2'd1, d); wr(2'd2, e); wr(2'd3, f);
    endtask

    task automatic t_reset();
        // R1: outputs quiet, all enables off after reset
        check("R1 data_key", data_key, 1'b0);
        check("R1 key_out", key_out, 1'b0);
        // R1: key values are 0 but keying is off: a zero pixel gives no key
        pix(2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R1 zero pixel");
    endtask

    task automatic t_modes();
        load_keys(8'h11, 8'h22, 8'h33);
        wr(2'd0, 8'h1E);
        pix(2'd0, 8'h33, 8'h11, 8'h22, 1'b0, 1'b1, 1'b1, "R2 gbr match");
        pix(2'd0, 8'h34, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0, "R2 gbr miss");
        pix(2'd1, 8'h11, 8'h22, 8'h33, 1'b0, 1'b1, 1'b1, "R3 rgb match");
        pix(2'd1, 8'h33, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0, "R3 rgb miss");
        pix(2'd2, 8'h33, 8'h11, 8'h22, 1'b0, 1'b1, 1'b1, "R4 yc match");
        pix(2'd2, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 1'b0, "R4 yc miss");
        // R7: one lane off by a single bit kills the key
        pix(2'd1, 8'h11, 8'h23, 8'h33, 1'b0, 1'b0, 1'b0, "R7 one lane miss");
    endtask

    task automatic t_enables();
        wr(2'd0, 8'h18); // master + D only
        pix(2'd1, 8'h11, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b1, "R6 only D enabled");
        wr(2'd0, 8'h14); // master + E only
        pix(2'd1, 8'h11, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, "R6 only E enabled");
        wr(2'd0, 8'h10); // master, no lanes
        pix(2'd1, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 1'b0, "R9 no lane enabled");
        wr(2'd0, 8'h0E); // lanes, no master
        pix(2'd1, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 1'b0, "R8 master off");
    endtask

    task automatic t_index();
        load_keys(8'h11, 8'h22, 8'h33);
        wr(2'd0, 8'h1C); // master + D + E
        pix(2'd3, 8'h00, 8'h11, 8'h00, 1'b0, 1'b0, 1'b0, "R10 conflict idx D");
        pix(2'd3, 8'h00, 8'h22, 8'h00, 1'b0, 1'b0, 1'b0, "R10 conflict idx E");
        wr(2'd0, 8'h18); // D only
        pix(2'd3, 8'h00, 8'h11, 8'h00, 1'b0, 1'b1, 1'b1, "R10 single lane idx");
        // R5: red and blue are ignored in index mode
        pix(2'd3, 8'hAA, 8'h11, 8'h55, 1'b0, 1'b1, 1'b1, "R5 r/b ignored");
        wr(2'd2, 8'h11);
        wr(2'd0, 8'h1C);
        pix(2'd3, 8'h00, 8'h11, 8'h00, 1'b0, 1'b1, 1'b1, "R5 equal keys idx");
    endtask

    task automatic t_or_latency();
        wr(2'd0, 8'h00);
        // R11: before the edge the old value is still shown
        @(negedge clk);
        ext_key = 1'b1;
        #1 check("R11 key_out before edge", key_out, 1'b0);
        @(posedge clk); #1;
        check("R11 ext key after edge", key_out, 1'b1);
        check("R11 data_key stays 0", data_key, 1'b0);
        pix(2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R11 both off");
        wr(2'd0, 8'h1E);
        load_keys(8'h11, 8'h22, 8'h33);
        pix(2'd1, 8'h11, 8'h22, 8'h33, 1'b1, 1'b1, 1'b1, "R11 both on");
    endtask

    task automatic t_write_timing();
        load_keys(8'h11, 8'h22, 8'h33);
        wr(2'd0, 8'h18); // D only
        // R12: pixel sampled on the write edge uses the old key value
        @(negedge clk);
        mode = 2'd1; pix_r = 8'h5A; ext_key = 1'b0;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h5A;
        @(posedge clk); #1;
        check("R12 write edge uses old key", data_key, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        check("R12 next pixel uses new key", data_key, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_modes();
        t_enables();
        t_index();
        t_or_latency();
        t_write_timing();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule